// File: doc/BRIEF.md
# UART Interrupt Source and FIFO Trigger Controller

This block is the interrupt stage of a FIFO-buffered serial port. It watches the fill levels of the receive and transmit FIFOs, the error flags that come with each received character, an idle timer on the receive side, and four synchronised modem-status inputs. It gathers these into eleven raw status bits. Each bit can be enabled on its own, and a single interrupt line is raised while any enabled bit is set.

Software programs a trigger level for each direction as a 3-bit code that selects a fraction of the FIFO depth, in eighths. It enables sources through a mask register, reads a raw view and a masked view of the status, and acknowledges a source by writing a one to its position in a clear register. The serializer, the baud generator, the FIFO storage and any DMA path are outside this block. Those neighbours supply occupancy counts, push and pop strobes, the per-character error flags and a one-cycle tick for each bit period.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the mask, raw and masked registers read 0, `irq` is 0 and the trigger-level register reads 0x12 (both codes = 2).
- R2: Bit positions are the same in the mask (0x38), raw (0x3C), masked (0x40) and clear (0x44) registers: 10 overrun, 9 break, 8 parity, 7 framing, 6 receive timeout, 5 transmit, 4 receive, 3 DSR change, 2 DCD change, 1 CTS change, 0 RI change. The masked view is raw AND mask, and `irq` is 1 exactly when that masked view is non-zero.
- R3: Writing the clear register clears each raw bit written as 1 and leaves the other raw bits alone. Writes to the raw and masked addresses change nothing.
- R4: On a cycle with `rx_push` high, `rx_flags` bits 3, 2, 1 and 0 (overrun, break, parity, framing) set raw bits 10, 9, 8 and 7. These bits stay set until they are cleared.
- R5: The trigger-level register (0x34) holds the receive code in bits 5:3 and the transmit code in bits 2:0. Codes 0, 1, 2, 3 and 4 select 1/8, 1/4, 1/2, 3/4 and 7/8 of `DEPTH`. Codes 5 to 7 read back as written and act as code 4.
- R6: Raw bit 4 is set when the receive occupancy moves from below the selected level to at or above it. It clears by itself when the occupancy drops below the level, or when it is cleared, and it does not come back while the occupancy stays at or above the level.
- R7: Raw bit 5 is set when the transmit occupancy moves from above the selected level to at or below it. It clears by itself when the occupancy rises above the level. An empty transmit FIFO after reset does not set it.
- R8: Raw bit 6 is set on the 32nd `baud_tick` counted while the receive FIFO is non-empty with no `rx_push` or `rx_pop`. A push or a pop restarts the count.
- R9: Raw bit 6 clears on `rx_push`, on `rx_pop`, or when the receive FIFO becomes empty.
- R10: `modem_in` bits 3, 2, 1 and 0 (DSR, DCD, CTS, RI) pass through a two-stage synchroniser. Either edge of a line sets the matching raw bit 3, 2, 1 or 0, three clock edges after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 11 | Register write data |
| reg_rdata | output | 11 | Register read data for `reg_addr` (combinational) |
| rx_level | input | 5 | Receive FIFO occupancy, 0..DEPTH |
| tx_level | input | 5 | Transmit FIFO occupancy, 0..DEPTH |
| rx_push | input | 1 | A character was written into the receive FIFO |
| rx_flags | input | 4 | Error flags of that character: overrun, break, parity, framing |
| rx_pop | input | 1 | A character was read from the receive FIFO |
| baud_tick | input | 1 | One pulse per bit period |
| modem_in | input | 4 | Asynchronous DSR, DCD, CTS, RI levels |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest condition to reach from the ports is the receive timeout. It needs a long, unbroken run of bit-period ticks while the FIFO stays non-empty, and a push or pop anywhere in that run silently restarts it. The stimulus holds the occupancy at one and issues exactly 31 ticks, confirms the bit is still clear, inserts a push to restart the count, then repeats the 31 ticks before giving the deciding 32nd tick. The edge-only behaviour of the level interrupts is the other subtle case. It is reached by clearing the receive bit while the occupancy stays above the level and checking that the bit does not return.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int unsigned SRC_N = 11;

   // source bit positions, shared by mask, raw, masked and clear views
   localparam int unsigned SRC_RI  = 0;
   localparam int unsigned SRC_CTS = 1;
   localparam int unsigned SRC_DCD = 2;
   localparam int unsigned SRC_DSR = 3;
   localparam int unsigned SRC_RX  = 4;
   localparam int unsigned SRC_TX  = 5;
   localparam int unsigned SRC_RTO = 6;
   localparam int unsigned SRC_FE  = 7;
   localparam int unsigned SRC_PE  = 8;
   localparam int unsigned SRC_BE  = 9;
   localparam int unsigned SRC_OE  = 10;

   // register byte addresses
   localparam logic [7:0] ADR_LVL = 8'h34;
   localparam logic [7:0] ADR_MSK = 8'h38;
   localparam logic [7:0] ADR_RAW = 8'h3C;
   localparam logic [7:0] ADR_MIS = 8'h40;
   localparam logic [7:0] ADR_CLR = 8'h44;

   localparam logic [5:0] LVL_RESET = 6'b010_010;

   // trigger threshold in entries for a 3-bit code; codes above 4 act as 4
   function automatic int unsigned trig_thresh(input logic [2:0] code,
                                               input int unsigned depth);
      case (code)
         3'd0:    trig_thresh = depth / 8;
         3'd1:    trig_thresh = depth / 4;
         3'd2:    trig_thresh = depth / 2;
         3'd3:    trig_thresh = (depth * 3) / 4;
         default: trig_thresh = (depth * 7) / 8;
      endcase
   endfunction

endpackage

// File: rtl/uart_irq_level.sv
module uart_irq_level
   import uart_irq_pkg::*;
#(
   parameter int unsigned DEPTH      = 16,
   parameter int unsigned CNT_W      = $clog2(DEPTH + 1),
   parameter bit          RISE_ABOVE = 1'b1,
   parameter bit          HIT_INIT   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       code,
   input  logic [CNT_W-1:0] occ,
   output logic             hit,
   output logic             hit_rise
);

   logic [CNT_W-1:0] thr;
   logic             hit_q;

   assign thr = CNT_W'(trig_thresh(code, DEPTH));

   generate
      if (RISE_ABOVE) begin : g_above
         assign hit = (occ >= thr);
      end else begin : g_below
         assign hit = (occ <= thr);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_q <= HIT_INIT;
      else        hit_q <= hit;
   end

   assign hit_rise = hit && !hit_q;

endmodule

// File: rtl/uart_irq_rxto.sv
module uart_irq_rxto #(
   parameter int unsigned LIMIT = 32,
   parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nonempty,
   input  logic push,
   input  logic pop,
   input  logic tick,
   output logic fire,
   output logic cancel
);

   logic [CW-1:0] cnt_q;

   assign cancel = push || pop || !nonempty;
   assign fire   = tick && !cancel && (cnt_q == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             cnt_q <= '0;
      else if (cancel)                        cnt_q <= '0;
      else if (tick && cnt_q != CW'(LIMIT))   cnt_q <= cnt_q + 1'b1;
   end

   // R8
   to_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(LIMIT));

   // R9
   to_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push || pop) |=> (cnt_q == '0));

endmodule

// File: rtl/uart_irq_modem.sv
module uart_irq_modem #(
   parameter int unsigned LINES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] lines_in,
   output logic [LINES-1:0] edge_o
);

   generate
      for (genvar i = 0; i < LINES; i++) begin : g_line
         logic s1_q, s2_q, prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s1_q   <= 1'b0;
               s2_q   <= 1'b0;
               prev_q <= 1'b0;
            end else begin
               s1_q   <= lines_in[i];
               s2_q   <= s1_q;
               prev_q <= s2_q;
            end
         end
         assign edge_o[i] = s2_q ^ prev_q;
      end
   endgenerate

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int unsigned DEPTH        = 16,
   parameter int unsigned TIMEOUT_BITS = 32,
   parameter int unsigned LVL_W        = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [7:0]       reg_addr,
   input  logic [SRC_N-1:0] reg_wdata,
   output logic [SRC_N-1:0] reg_rdata,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] tx_level,
   input  logic             rx_push,
   input  logic [3:0]       rx_flags,
   input  logic             rx_pop,
   input  logic             baud_tick,
   input  logic [3:0]       modem_in,
   output logic             irq
);

   localparam int unsigned MDM_N = 4;

   generate
      if (DEPTH < 8 || (DEPTH % 8) != 0) begin : g_bad_depth
         $error("DEPTH must be a non-zero multiple of 8");
      end
      if (TIMEOUT_BITS < 2) begin : g_bad_to
         $error("TIMEOUT_BITS must be at least 2");
      end
   endgenerate

   logic [5:0]       lvl_q;
   logic [SRC_N-1:0] mask_q, raw_q, raw_d, set_v, clr_v, mis;
   logic             rx_hit, rx_rise, tx_hit, tx_rise;
   logic             to_fire, to_cancel;
   logic [MDM_N-1:0] mdm_edge;

   uart_irq_level #(.DEPTH(DEPTH), .CNT_W(LVL_W), .RISE_ABOVE(1'b1), .HIT_INIT(1'b0))
   u_rx_lvl (
      .clk(clk), .rst_n(rst_n), .code(lvl_q[5:3]), .occ(rx_level),
      .hit(rx_hit), .hit_rise(rx_rise)
   );

   uart_irq_level #(.DEPTH(DEPTH), .CNT_W(LVL_W), .RISE_ABOVE(1'b0), .HIT_INIT(1'b1))
   u_tx_lvl (
      .clk(clk), .rst_n(rst_n), .code(lvl_q[2:0]), .occ(tx_level),
      .hit(tx_hit), .hit_rise(tx_rise)
   );

   uart_irq_rxto #(.LIMIT(TIMEOUT_BITS)) u_rxto (
      .clk(clk), .rst_n(rst_n), .nonempty(rx_level != '0),
      .push(rx_push), .pop(rx_pop), .tick(baud_tick),
      .fire(to_fire), .cancel(to_cancel)
   );

   uart_irq_modem #(.LINES(MDM_N)) u_modem (
      .clk(clk), .rst_n(rst_n), .lines_in(modem_in), .edge_o(mdm_edge)
   );

   // set events per source
   always_comb begin
      set_v          = '0;
      set_v[SRC_OE]  = rx_push && rx_flags[3];
      set_v[SRC_BE]  = rx_push && rx_flags[2];
      set_v[SRC_PE]  = rx_push && rx_flags[1];
      set_v[SRC_FE]  = rx_push && rx_flags[0];
      set_v[SRC_RTO] = to_fire;
      set_v[SRC_TX]  = tx_rise;
      set_v[SRC_RX]  = rx_rise;
      set_v[SRC_DSR:SRC_RI] = mdm_edge;
   end

   assign clr_v = (reg_wr && reg_addr == ADR_CLR) ? reg_wdata : '0;

   always_comb begin
      raw_d = set_v | (raw_q & ~clr_v);
      raw_d[SRC_RX]  = rx_rise || (raw_q[SRC_RX] && !clr_v[SRC_RX] && rx_hit);
      raw_d[SRC_TX]  = tx_rise || (raw_q[SRC_TX] && !clr_v[SRC_TX] && tx_hit);
      raw_d[SRC_RTO] = to_fire || (raw_q[SRC_RTO] && !clr_v[SRC_RTO] && !to_cancel);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= LVL_RESET;
         mask_q <= '0;
         raw_q  <= '0;
      end else begin
         raw_q <= raw_d;
         if (reg_wr && reg_addr == ADR_LVL) lvl_q  <= reg_wdata[5:0];
         if (reg_wr && reg_addr == ADR_MSK) mask_q <= reg_wdata;
      end
   end

   assign mis = raw_q & mask_q;
   assign irq = |mis;

   always_comb begin
      case (reg_addr)
         ADR_LVL: reg_rdata = {{(SRC_N-6){1'b0}}, lvl_q};
         ADR_MSK: reg_rdata = mask_q;
         ADR_RAW: reg_rdata = raw_q;
         ADR_MIS: reg_rdata = mis;
         default: reg_rdata = '0;
      endcase
   end

   // R2
   irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (mask_q != '0));

   // R3
   oe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADR_CLR && reg_wdata[SRC_OE] && !(rx_push && rx_flags[3]))
      |=> !raw_q[SRC_OE]);

   // R6
   rx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_q[SRC_RX]) |-> $past(rx_hit));

   // R7
   tx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_q[SRC_TX]) |-> $past(tx_hit));

   // R10
   cts_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_q[SRC_CTS]) |-> $past(mdm_edge[1]));

endmodule

// File: tb/sim_uart_irq_ctrl.sv
`timescale 1ns/1ps
module sim_uart_irq_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [10:0] reg_wdata = '0;
   logic [10:0] reg_rdata;
   logic [4:0]  rx_level = '0;
   logic [4:0]  tx_level = '0;
   logic        rx_push = 1'b0;
   logic [3:0]  rx_flags = '0;
   logic        rx_pop = 1'b0;
   logic        baud_tick = 1'b0;
   logic [3:0]  modem_in = '0;
   logic        irq;

   int vecs = 0;
   int errs = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   uart_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_level(rx_level),
      .tx_level(tx_level), .rx_push(rx_push), .rx_flags(rx_flags),
      .rx_pop(rx_pop), .baud_tick(baud_tick), .modem_in(modem_in), .irq(irq)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [10:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [10:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic clear_all();
      wr(8'h44, 11'h7FF);
   endtask

   task automatic t_reset();
      logic [10:0] d;
      rd(8'h38, d); chk("R1 mask", d, 0);
      rd(8'h3C, d); chk("R1 raw", d, 0);
      rd(8'h40, d); chk("R1 masked", d, 0);
      rd(8'h34, d); chk("R1 level", d, 11'h12);
      chk("R1 irq", irq, 0);
   endtask

   task automatic t_errors_mask();
      logic [10:0] d;
      rx_push = 1'b1; rx_flags = 4'b1000; step();
      rx_push = 1'b0; rx_flags = 4'b0000;
      rd(8'h3C, d); chk("R4 overrun raw bit10", d, 11'h400);
      rd(8'h40, d); chk("R2 masked zero with mask 0", d, 0);
      chk("R2 irq off while masked", irq, 0);
      wr(8'h38, 11'h400);
      rd(8'h40, d); chk("R2 masked view", d, 11'h400);
      chk("R2 irq on", irq, 1);
      rx_push = 1'b1; rx_flags = 4'b0111; step();
      rx_push = 1'b0; rx_flags = 4'b0000;
      rd(8'h3C, d); chk("R4 break/parity/framing bits 9..7", d, 11'h780);
      rx_flags = 4'b1111; step(); rx_flags = 4'b0000;
      wr(8'h3C, 11'h000); wr(8'h40, 11'h000);
      rd(8'h3C, d); chk("R3 raw/masked writes ignored, flags without push ignored", d, 11'h780);
      wr(8'h44, 11'h500);
      rd(8'h3C, d); chk("R3 clear only written bits", d, 11'h280);
      chk("R2 irq off after clear", irq, 0);
      wr(8'h38, 11'h000);
      clear_all();
      rd(8'h3C, d); chk("R3 clear all", d, 0);
   endtask

   task automatic t_rx_level();
      logic [10:0] d;
      wr(8'h34, 11'h002);           // rx code 0 -> 2 entries
      rx_level = 5'd1; step();
      rd(8'h3C, d); chk("R6 below 1/8", d[4], 0);
      rx_level = 5'd2; step();
      rd(8'h3C, d); chk("R6 reach 1/8", d[4], 1);
      clear_all(); step();
      rd(8'h3C, d); chk("R6 no re-set while above", d[4], 0);
      rx_level = 5'd0; step();
      wr(8'h34, 11'h022);           // rx code 4 -> 14 entries
      rx_level = 5'd13; step();
      rd(8'h3C, d); chk("R5 code 4 below 7/8", d[4], 0);
      rx_level = 5'd14; step();
      rd(8'h3C, d); chk("R5 code 4 at 7/8", d[4], 1);
      rx_level = 5'd3; step();
      rd(8'h3C, d); chk("R6 self-clear below level", d[4], 0);
      wr(8'h34, 11'h03A);           // rx code 7 (reserved)
      rd(8'h34, d); chk("R5 reserved code reads back", d, 11'h03A);
      rx_level = 5'd13; step();
      rd(8'h3C, d); chk("R5 code 7 acts as 7/8, 13", d[4], 0);
      rx_level = 5'd14; step();
      rd(8'h3C, d); chk("R5 code 7 acts as 7/8, 14", d[4], 1);
      rx_level = 5'd0; step();
      wr(8'h34, 11'h012);
      clear_all();
   endtask

   task automatic t_tx_level();
      logic [10:0] d;
      rd(8'h3C, d); chk("R7 empty tx after reset no irq", d[5], 0);
      tx_level = 5'd9; step();
      rd(8'h3C, d); chk("R7 above half", d[5], 0);
      tx_level = 5'd8; step();
      rd(8'h3C, d); chk("R7 fall to half", d[5], 1);
      tx_level = 5'd12; step();
      rd(8'h3C, d); chk("R7 self-clear above", d[5], 0);
      tx_level = 5'd13; step();
      wr(8'h34, 11'h013);           // tx code 3 -> 12 entries
      tx_level = 5'd12; step();
      rd(8'h3C, d); chk("R5 tx code 3 at 3/4", d[5], 1);
      wr(8'h34, 11'h012);
      tx_level = 5'd0; step();
      clear_all();
      rd(8'h3C, d); chk("R3 tx cleared", d[5], 0);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         baud_tick = 1'b1; step();
         baud_tick = 1'b0; step();
      end
   endtask

   task automatic t_timeout();
      logic [10:0] d;
      rx_level = 5'd1; step();
      ticks(31);
      rd(8'h3C, d); chk("R8 31 ticks not yet", d[6], 0);
      rx_push = 1'b1; step(); rx_push = 1'b0;
      ticks(31);
      rd(8'h3C, d); chk("R8 restart after push", d[6], 0);
      ticks(1);
      rd(8'h3C, d); chk("R8 fires on 32nd tick", d[6], 1);
      wr(8'h38, 11'h040);
      chk("R2 irq from timeout", irq, 1);
      rx_pop = 1'b1; step(); rx_pop = 1'b0;
      rd(8'h3C, d); chk("R9 pop clears timeout", d[6], 0);
      ticks(32);
      rd(8'h3C, d); chk("R8 fires again", d[6], 1);
      rx_push = 1'b1; step(); rx_push = 1'b0;
      rd(8'h3C, d); chk("R9 push clears timeout", d[6], 0);
      ticks(32);
      rx_level = 5'd0; step();
      rd(8'h3C, d); chk("R9 empty clears timeout", d[6], 0);
      wr(8'h38, 11'h000);
      clear_all();
   endtask

   task automatic t_modem();
      logic [10:0] d;
      modem_in = 4'b0010; step();
      rd(8'h3C, d); chk("R10 not before sync delay", d, 0);
      step(); step();
      rd(8'h3C, d); chk("R10 CTS rising -> bit1", d, 11'h002);
      clear_all();
      modem_in = 4'b0000; step(); step(); step();
      rd(8'h3C, d); chk("R10 CTS falling -> bit1", d, 11'h002);
      clear_all();
      modem_in = 4'b1000; step(); step(); step();
      rd(8'h3C, d); chk("R10 DSR -> bit3", d, 11'h008);
      clear_all();
      modem_in = 4'b1101; step(); step(); step();
      rd(8'h3C, d); chk("R10 DCD and RI -> bits 2,0", d, 11'h005);
      modem_in = 4'b0000; step(); step(); step();
      clear_all();
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errs++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset();
      t_errors_mask();
      t_rx_level();
      t_tx_level();
      t_timeout();
      t_modem();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

endmodule